// File: doc/BRIEF.md
# Decoded 64-bit Logical Right Shifter

This block is the execute slice for one register-register instruction: a 64-bit logical right shift by a count held in a register. It takes a 32-bit instruction word, the value to shift, the count operand and the current summary-overflow bit. From the word it decodes whether this is the instruction it implements, which registers to read and which to write, and whether the record form was requested.

The read indices for the value and count registers are decoded combinationally so that a register file can be addressed in the same cycle. The result is registered at the next rising clock edge. It comes out with the destination index and a write enable. When the record form is selected, a 4-bit condition field is also registered, together with its own enable. Only the low seven bits of the count operand matter. Counts of 64 and above clear the result rather than wrapping.

Top module: `shr_exec`

## Requirements
- R1: The word is recognised only when bits [31:26] equal 31 and bits [10:1] equal 539; the word 0x7C000436 is the instance with all register fields zero.
- R2: The value-register read index comes from bits [25:21], the destination index from bits [20:16], the count-register read index from bits [15:11], and the record flag from bit [0].
- R3: Only bits [6:0] of the count operand form the shift amount; every higher bit has no effect on any output.
- R4: For an amount below 64 the result equals the value operand shifted right by the amount, with zeros entering at bit 63.
- R5: For an amount from 64 to 127 the result is exactly zero.
- R6: A recognised word always asserts the result write enable, whatever the record flag.
- R7: The condition field is ordered {LT, GT, EQ, SO} from bit 3 down to bit 0, with LT, GT and EQ taken from a signed comparison of the 64-bit result against zero; exactly one of them is set.
- R8: The condition enable is asserted only for a recognised word whose record flag is 1.
- R9: Bit 0 of the condition field equals the summary-overflow input sampled with the word.
- R10: An unrecognised word leaves both write enables deasserted.
- R11: An amount of zero passes the value operand through unchanged, so a negative value yields LT set.
- R12: Registered outputs appear one rising edge after the inputs are applied; while reset is held, the outputs are zero.
- R13: With a nonzero amount, bit 63 of the result is clear, so the condition field never shows LT.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_word | input | 32 | Instruction word to decode |
| src_val | input | 64 | Value operand to shift |
| cnt_val | input | 64 | Count operand (low 7 bits used) |
| so_in | input | 1 | Summary-overflow bit to copy into the condition field |
| src_idx | output | 5 | Combinational read index for the value register |
| cnt_idx | output | 5 | Combinational read index for the count register |
| dst_idx | output | 5 | Registered destination register index |
| wb_data | output | 64 | Registered shift result |
| wb_we | output | 1 | Registered result write enable |
| cr_data | output | 4 | Registered condition field {LT, GT, EQ, SO} |
| cr_we | output | 1 | Registered condition field write enable |

## Verification
The two read indices are due in the same cycle as the word and are sampled shortly after it is driven. Every other output is due one rising edge later. The bench applies inputs just after a falling edge and samples at the next falling edge, which is half a period after the one register stage has loaded. The sweep covers all 128 amounts on several value patterns, with garbage in the upper count bits, and alternates the record flag and the summary-overflow bit. Separate words exercise both opcode mismatches and the reset state.

// File: rtl/shr_pkg.sv
package shr_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned PRI_W  = 6;
  localparam int unsigned EXT_W  = 10;

  // condition field, most significant member first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  // signed compare against zero, from the sign bit and a zero flag
  function automatic cond_t make_cond(input logic sign_bit, input logic is_zero,
                                      input logic so_bit);
    cond_t c;
    c.lt = sign_bit;
    c.eq = is_zero;
    c.gt = !sign_bit && !is_zero;
    c.so = so_bit;
    return c;
  endfunction

endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
#(
  parameter int unsigned PRIM_OP = 31,
  parameter int unsigned EXT_OP  = 539
) (
  input  logic [INSN_W-1:0] insn,
  output logic              match,
  output logic              rec_flag,
  output logic [IDX_W-1:0]  rs_field,
  output logic [IDX_W-1:0]  rd_field,
  output logic [IDX_W-1:0]  rb_field
);
  localparam logic [PRI_W-1:0] PRI_VAL = PRI_W'(PRIM_OP);
  localparam logic [EXT_W-1:0] EXT_VAL = EXT_W'(EXT_OP);

  logic pri_hit;
  logic ext_hit;

  always_comb begin
    pri_hit  = (insn[31:26] == PRI_VAL);
    ext_hit  = (insn[10:1] == EXT_VAL);
    match    = pri_hit && ext_hit;
    rec_flag = insn[0];
    rs_field = insn[25:21];
    rd_field = insn[20:16];
    rb_field = insn[15:11];
  end
endmodule

// File: rtl/shr_shift.sv
module shr_shift #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  amt,
  output logic              out_of_range,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned STG = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [0:STG];

  assign stage[0] = src;

  genvar k;
  generate
    for (k = 0; k < STG; k++) begin : g_stage
      localparam int unsigned SH = 1 << k;
      assign stage[k+1] = amt[k] ? {{SH{1'b0}}, stage[k][DATA_W-1:SH]} : stage[k];
    end
  endgenerate

  assign out_of_range = |amt[CNT_W-1:STG];
  assign res = out_of_range ? '0 : stage[STG];
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] res,
  input  logic              so_bit,
  output cond_t             cond
);
  logic res_zero;
  logic res_neg;

  assign res_zero = (res == '0);
  assign res_neg  = res[DATA_W-1];
  assign cond     = make_cond(res_neg, res_zero, so_bit);
endmodule

// File: rtl/shr_exec.sv
module shr_exec
  import shr_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned PRIM_OP = 31,
  parameter int unsigned EXT_OP  = 539
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       insn_word,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              so_in,
  output logic [4:0]        src_idx,
  output logic [4:0]        cnt_idx,
  output logic [4:0]        dst_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_we,
  output logic [3:0]        cr_data,
  output logic              cr_we
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  // named internal events
  logic              match_w;
  logic              rec_w;
  logic [IDX_W-1:0]  rd_w;
  logic [CNT_W-1:0]  amt_w;
  logic              oor_w;
  logic [DATA_W-1:0] shift_res_w;
  cond_t             cond_w;
  logic              cnt_hi_unused;

  assign amt_w         = cnt_val[CNT_W-1:0];
  assign cnt_hi_unused = ^cnt_val[DATA_W-1:CNT_W];

  shr_decode #(.PRIM_OP(PRIM_OP), .EXT_OP(EXT_OP)) u_decode (
    .insn     (insn_word),
    .match    (match_w),
    .rec_flag (rec_w),
    .rs_field (src_idx),
    .rd_field (rd_w),
    .rb_field (cnt_idx)
  );

  shr_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .src          (src_val),
    .amt          (amt_w),
    .out_of_range (oor_w),
    .res          (shift_res_w)
  );

  shr_flags #(.DATA_W(DATA_W)) u_flags (
    .res    (shift_res_w),
    .so_bit (so_in),
    .cond   (cond_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_idx <= '0;
      wb_data <= '0;
      wb_we   <= 1'b0;
      cr_data <= '0;
      cr_we   <= 1'b0;
    end else begin
      dst_idx <= rd_w;
      wb_data <= shift_res_w;
      wb_we   <= match_w;
      cr_data <= cond_w;
      cr_we   <= match_w && rec_w;
    end
  end

  AST_RANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    oor_w |-> (shift_res_w == '0)); // R5
  AST_ZERO_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_w == '0) |-> (shift_res_w == src_val)); // R11
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_w != '0) |-> !shift_res_w[DATA_W-1]); // R13
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_data[3:1]) == 1)); // R7
  AST_COND_NEEDS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> wb_we); // R8
  AST_SO_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> (cr_data[0] == $past(so_in))); // R9
endmodule

// File: tb/shr_exec_bench.sv
module shr_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn_word = '0;
  logic [63:0] src_val = '0;
  logic [63:0] cnt_val = '0;
  logic        so_in = 1'b0;
  logic [4:0]  src_idx, cnt_idx, dst_idx;
  logic [63:0] wb_data;
  logic        wb_we;
  logic [3:0]  cr_data;
  logic        cr_we;

  int errors = 0;
  int checks = 0;

  shr_exec u_shr_exec (
    .clk(clk), .rst_n(rst_n), .insn_word(insn_word), .src_val(src_val),
    .cnt_val(cnt_val), .so_in(so_in), .src_idx(src_idx), .cnt_idx(cnt_idx),
    .dst_idx(dst_idx), .wb_data(wb_data), .wb_we(wb_we), .cr_data(cr_data),
    .cr_we(cr_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_word(input int pri, input int ext, input int rs,
                                          input int rd, input int rb, input bit rc);
    return {pri[5:0], rs[4:0], rd[4:0], rb[4:0], ext[9:0], rc};
  endfunction

  // bit-by-bit reference: result bit i takes source bit i+n
  function automatic logic [63:0] ref_shift(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++)
      if (i + n < 64) r[i] = v[i + n];
    return r;
  endfunction

  function automatic logic [3:0] ref_cond(input logic [63:0] r, input bit so);
    logic signed [63:0] s = r;
    return {s < 0, s > 0, s == 0, so};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [63:0] s,
                       input logic [63:0] c, input bit so);
    @(negedge clk);
    insn_word = w; src_val = s; cnt_val = c; so_in = so;
    #1;
  endtask

  task automatic run_op(input logic [63:0] s, input int n, input bit rc,
                        input bit so, input int rd);
    logic [63:0] exp;
    logic [63:0] cnt;
    int rs, rb;
    rs = (n * 3 + 1) % 32;
    rb = (n * 7 + 2) % 32;
    cnt = 64'hDEAD_BEEF_CAFE_0000 | 64'(n); // R3 garbage above bit 6
    cnt[15:7] = 9'h1A5;
    apply(mk_word(31, 539, rs, rd, rb, rc), s, cnt, so);
    chk("R2 src_idx", 64'(src_idx), 64'(rs));
    chk("R2 cnt_idx", 64'(cnt_idx), 64'(rb));
    @(negedge clk);
    exp = ref_shift(s, n);
    if (n >= 64) chk("R5 zero", wb_data, 64'd0);
    else if (n == 0) chk("R11 pass", wb_data, s);
    else chk("R4 R3 shift", wb_data, exp);
    chk("R6 wb_we", 64'(wb_we), 64'd1);
    chk("R2 dst_idx", 64'(dst_idx), 64'(rd));
    chk("R8 cr_we", 64'(cr_we), 64'(rc));
    if (rc) begin
      chk("R7 R9 cond", 64'(cr_data), 64'(ref_cond(exp, so)));
      if (n != 0) chk("R13 no LT", 64'(cr_data[3]), 64'd0);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [63:0] pats [0:3];
    pats[0] = 64'h8000_0000_0000_0001;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hF0E1_D2C3_B4A5_9687;
    pats[3] = 64'h0000_0000_0000_0000;

    // R12 reset state
    apply(mk_word(31, 539, 1, 2, 3, 1'b1), 64'hFFFF, 64'd0, 1'b1);
    @(negedge clk);
    chk("R12 reset wb_we", 64'(wb_we), 64'd0);
    chk("R12 reset cr_we", 64'(cr_we), 64'd0);
    chk("R12 reset data", wb_data, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 canonical word
    apply(32'h7C00_0436, 64'h1234, 64'd4, 1'b0);
    @(negedge clk);
    chk("R1 canonical wb_we", 64'(wb_we), 64'd1);
    chk("R1 canonical data", wb_data, 64'h123);

    // main sweep over all 128 amounts
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 128; n++)
        run_op(pats[p], n, bit'((n + p) % 2), bit'((n / 2 + p) % 2), (n + p) % 32);

    // R11 negative value with zero amount gives LT
    run_op(64'h8000_0000_0000_0000, 0, 1'b1, 1'b0, 9);
    chk("R11 LT", 64'(cr_data), 64'b1000);

    // R10 / R1 mismatches
    apply(mk_word(30, 539, 1, 2, 3, 1'b1), 64'hFF, 64'd1, 1'b1);
    @(negedge clk);
    chk("R10 pri mismatch wb_we", 64'(wb_we), 64'd0);
    chk("R10 pri mismatch cr_we", 64'(cr_we), 64'd0);
    apply(mk_word(31, 538, 1, 2, 3, 1'b1), 64'hFF, 64'd1, 1'b1);
    @(negedge clk);
    chk("R10 ext mismatch wb_we", 64'(wb_we), 64'd0);
    chk("R10 ext mismatch cr_we", 64'(cr_we), 64'd0);
    apply(mk_word(31, 795, 1, 2, 3, 1'b0), 64'hFF, 64'd1, 1'b0);
    @(negedge clk);
    chk("R1 ext high bit wb_we", 64'(wb_we), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule